// File: doc/BRIEF.md
# Quadrature Angular and Revolution Position Counter

This block keeps the shaft position of a motor fitted with an incremental quadrature encoder. Edge extraction and filtering happen upstream. Each clock the block may receive a count strobe, the current rotation direction and an already qualified index pulse. It keeps one W-bit position word. The low part of the word is an angular count inside one revolution. The high part is a signed-free revolution count. Both parts wrap between zero and their own upper limit.

The split point between the parts is a runtime setting. The upper limits are either all ones or taken from a period word. Four operating modes are accepted. The two relaxed modes let every index pulse re-align the angle and advance the revolution count. The two strict modes use only the first index pulse after enable to zero the angle. After that, the revolution count follows angular wraps alone. Two sticky flags report angular wraps and arrival at the end of the range. Software clears each flag with a write-one pulse.

Top module: `qdec_pos_counter`

## Requirements
- R1: During reset, all counts and both flags are zero. While `enable` is low, the next clock edge forces `ang_cnt` and `rev_cnt` to zero and re-arms the first-index detection. The flags are not touched by `enable`.
- R2: `ang_bits` sets the angular field width N; a value of 0 is taken as 1 and values above W-1 are taken as W-1. `pos_cnt` equals `(rev_cnt << N) | ang_cnt`. With `period_en` low, the angular top is N ones and the revolution top is W-N ones. With `period_en` high, the angular top is `period_val[N-1:0]` and the revolution top is `period_val[W-1:N]`.
- R3: A `tick` with `dir_up` high and `ang_cnt` at or above the angular top loads zero into `ang_cnt` on that clock edge and sets `ovf_flag`. Otherwise it increments `ang_cnt`.
- R4: A `tick` with `dir_up` low and `ang_cnt` equal to zero loads the angular top and sets `ovf_flag`. Otherwise it decrements `ang_cnt`.
- R5: In relaxed modes (`mode` 0 or 1) with `index_en` high, an `index` pulse loads zero when `dir_up` is high and the angular top when it is low. It steps `rev_cnt` one position in the count direction and takes precedence over a `tick` in the same cycle. Angular wraps then leave `rev_cnt` unchanged.
- R6: In relaxed modes with `index_en` low, `index` has no effect and `rev_cnt` steps once on every angular wrap.
- R7: In strict modes (`mode` 2 or 3) with `index_en` high, only the first `index` pulse since `enable` rose loads zero into `ang_cnt`. It takes precedence over a simultaneous `tick`. Later pulses have no effect. In strict modes, `rev_cnt` steps on every angular wrap whatever `index_en` is.
- R8: The revolution count wraps within its own range. Stepping up from a value at or above the revolution top gives zero. Stepping down from zero gives the revolution top.
- R9: `mc0_flag` sets when a tick step that is not a wrap leaves `ang_cnt` equal to the angular top while counting up, or equal to zero while counting down.
- R10: Both flags stay set until a high `clr_ovf` / `clr_mc0` in a cycle with no new set. A clear in the same cycle as a set leaves the flag set.
- R11: With `enable` high and neither `tick` nor `index`, both counts hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| enable | input | 1 | Counting enable; low clears counts and re-arms first index |
| tick | input | 1 | One-cycle count strobe from edge extraction |
| dir_up | input | 1 | Count direction, 1 = up |
| index | input | 1 | Qualified index pulse |
| index_en | input | 1 | Index use enable |
| mode | input | 2 | 0/1 relaxed (two or four edges), 2/3 strict |
| period_en | input | 1 | Take tops from `period_val` |
| ang_bits | input | $clog2(W) | Angular field width N |
| period_val | input | W | Period word holding both tops |
| clr_ovf | input | 1 | Write-one clear of `ovf_flag` |
| clr_mc0 | input | 1 | Write-one clear of `mc0_flag` |
| ang_cnt | output | W | Angular count, right aligned |
| rev_cnt | output | W | Revolution count, right aligned |
| pos_cnt | output | W | Combined position word |
| ovf_flag | output | 1 | Sticky angular wrap flag |
| mc0_flag | output | 1 | Sticky end-of-range flag |

## Verification
Runs of up-only ticks, down-only ticks and direction reversals show the two wrap directions and the end-of-range flag. Each pattern pins which limit each direction reloads. Index pulses are placed mid-revolution, on the same cycle as a tick, and repeatedly after enable. These placements show relaxed re-alignment, strict first-only zeroing and the source of the revolution step. The bench also uses default tops against period-derived tops, and width settings of zero, one and wide. These settings separate the clamp and field-split rules. A long randomized stretch changes the configuration only while counting is disabled. It mixes all of the above against a behavioural model on every clock.

// File: rtl/qpc_pkg.sv
package qpc_pkg;

  typedef enum logic [1:0] {
    QPC_REL2 = 2'd0,
    QPC_REL4 = 2'd1,
    QPC_STR2 = 2'd2,
    QPC_STR4 = 2'd3
  } qpc_mode_e;

  localparam int QPC_FLAG_OVF = 0;
  localparam int QPC_FLAG_MC0 = 1;
  localparam int QPC_NFLAGS   = 2;

  function automatic logic qpc_is_strict(input qpc_mode_e m);
    return (m == QPC_STR2) || (m == QPC_STR4);
  endfunction

endpackage

// File: rtl/qpc_limits.sv
module qpc_limits #(
  parameter int W  = 16,
  parameter int NW = $clog2(W)
) (
  input  logic [NW-1:0] ang_bits,
  input  logic          period_en,
  input  logic [W-1:0]  period_val,
  output logic [NW-1:0] ang_n,
  output logic [W-1:0]  ang_top,
  output logic [W-1:0]  rev_top
);

  localparam logic [NW-1:0] NMAX = NW'(W - 1);
  localparam logic [W-1:0]  ONES = {W{1'b1}};

  logic [W-1:0] ang_mask;
  logic [W-1:0] rev_mask;

  always_comb begin
    if (ang_bits == '0) begin
      ang_n = NW'(1);
    end else if (ang_bits > NMAX) begin
      ang_n = NMAX;
    end else begin
      ang_n = ang_bits;
    end
  end

  always_comb begin
    ang_mask = ~(ONES << ang_n);
    rev_mask = ONES >> ang_n;
    if (period_en) begin
      ang_top = period_val & ang_mask;
      rev_top = (period_val >> ang_n) & rev_mask;
    end else begin
      ang_top = ang_mask;
      rev_top = rev_mask;
    end
  end

endmodule

// File: rtl/qpc_angular.sv
module qpc_angular #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         tick,
  input  logic         up,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] top,
  output logic [W-1:0] ang_q,
  output logic         wrap,
  output logic         hit
);

  logic [W-1:0] ang_d;
  logic         ang_en;

  always_comb begin
    ang_d  = ang_q;
    ang_en = 1'b0;
    wrap   = 1'b0;
    hit    = 1'b0;
    if (!run) begin
      ang_d  = '0;
      ang_en = 1'b1;
    end else if (load) begin
      ang_d  = load_val;
      ang_en = 1'b1;
    end else if (tick) begin
      ang_en = 1'b1;
      if (up) begin
        if (ang_q >= top) begin
          ang_d = '0;
          wrap  = 1'b1;
        end else begin
          ang_d = ang_q + W'(1);
          hit   = ((ang_q + W'(1)) == top);
        end
      end else begin
        if (ang_q == '0) begin
          ang_d = top;
          wrap  = 1'b1;
        end else begin
          ang_d = ang_q - W'(1);
          hit   = (ang_q == W'(1));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ang_q <= '0;
    end else if (ang_en) begin
      ang_q <= ang_d;
    end
  end

endmodule

// File: rtl/qpc_revolution.sv
module qpc_revolution #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         run,
  input  logic         step,
  input  logic         up,
  input  logic [W-1:0] top,
  output logic [W-1:0] rev_q
);

  logic [W-1:0] rev_d;
  logic         rev_en;

  always_comb begin
    rev_d  = rev_q;
    rev_en = 1'b0;
    if (!run) begin
      rev_d  = '0;
      rev_en = 1'b1;
    end else if (step) begin
      rev_en = 1'b1;
      if (up) begin
        rev_d = (rev_q >= top) ? '0 : rev_q + W'(1);
      end else begin
        rev_d = (rev_q == '0) ? top : rev_q - W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_q <= '0;
    end else if (rev_en) begin
      rev_q <= rev_d;
    end
  end

endmodule

// File: rtl/qpc_flags.sv
module qpc_flags #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flag_q
);

  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_d;
    logic flag_en;

    always_comb begin
      flag_en = set[g] | clr[g];
      flag_d  = set[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        flag_q[g] <= 1'b0;
      end else if (flag_en) begin
        flag_q[g] <= flag_d;
      end
    end
  end

endmodule

// File: rtl/qdec_pos_counter.sv
module qdec_pos_counter
  import qpc_pkg::*;
#(
  parameter  int W  = 16,
  localparam int NW = $clog2(W)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic          dir_up,
  input  logic          index,
  input  logic          index_en,
  input  logic [1:0]    mode,
  input  logic          period_en,
  input  logic [NW-1:0] ang_bits,
  input  logic [W-1:0]  period_val,
  input  logic          clr_ovf,
  input  logic          clr_mc0,
  output logic [W-1:0]  ang_cnt,
  output logic [W-1:0]  rev_cnt,
  output logic [W-1:0]  pos_cnt,
  output logic          ovf_flag,
  output logic          mc0_flag
);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end

  assign rst_int_n = rst_sync_q[1];

  // configuration decode
  qpc_mode_e    mode_e;
  logic         strict;
  logic [NW-1:0] ang_n;
  logic [W-1:0] ang_top;
  logic [W-1:0] rev_top;

  assign mode_e = qpc_mode_e'(mode);
  assign strict = qpc_is_strict(mode_e);

  qpc_limits #(.W(W), .NW(NW)) u_limits (
    .ang_bits  (ang_bits),
    .period_en (period_en),
    .period_val(period_val),
    .ang_n     (ang_n),
    .ang_top   (ang_top),
    .rev_top   (rev_top)
  );

  // first-index tracking for strict modes
  logic armed_seen_q;
  logic armed_seen_d;
  logic armed_en;
  logic idx_ok;
  logic first_idx;

  assign idx_ok    = enable & index_en & index;
  assign first_idx = strict & idx_ok & ~armed_seen_q;

  always_comb begin
    armed_en     = 1'b0;
    armed_seen_d = armed_seen_q;
    if (!enable) begin
      armed_en     = 1'b1;
      armed_seen_d = 1'b0;
    end else if (first_idx) begin
      armed_en     = 1'b1;
      armed_seen_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      armed_seen_q <= 1'b0;
    end else if (armed_en) begin
      armed_seen_q <= armed_seen_d;
    end
  end

  // angular reload and revolution step selection
  logic         ang_load;
  logic [W-1:0] ang_load_val;
  logic         ang_wrap;
  logic         ang_hit;
  logic         rev_step;

  always_comb begin
    if (strict) begin
      ang_load     = first_idx;
      ang_load_val = '0;
      rev_step     = ang_wrap;
    end else begin
      ang_load     = idx_ok;
      ang_load_val = dir_up ? '0 : ang_top;
      rev_step     = index_en ? idx_ok : ang_wrap;
    end
  end

  qpc_angular #(.W(W)) u_angular (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .run     (enable),
    .tick    (tick),
    .up      (dir_up),
    .load    (ang_load),
    .load_val(ang_load_val),
    .top     (ang_top),
    .ang_q   (ang_cnt),
    .wrap    (ang_wrap),
    .hit     (ang_hit)
  );

  qpc_revolution #(.W(W)) u_revolution (
    .clk  (clk),
    .rst_n(rst_int_n),
    .run  (enable),
    .step (rev_step),
    .up   (dir_up),
    .top  (rev_top),
    .rev_q(rev_cnt)
  );

  // sticky flags
  logic [QPC_NFLAGS-1:0] flag_set;
  logic [QPC_NFLAGS-1:0] flag_clr;
  logic [QPC_NFLAGS-1:0] flag_q;

  always_comb begin
    flag_set               = '0;
    flag_clr               = '0;
    flag_set[QPC_FLAG_OVF] = ang_wrap;
    flag_set[QPC_FLAG_MC0] = ang_hit;
    flag_clr[QPC_FLAG_OVF] = clr_ovf;
    flag_clr[QPC_FLAG_MC0] = clr_mc0;
  end

  qpc_flags #(.N(QPC_NFLAGS)) u_flags (
    .clk   (clk),
    .rst_n (rst_int_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .flag_q(flag_q)
  );

  assign ovf_flag = flag_q[QPC_FLAG_OVF];
  assign mc0_flag = flag_q[QPC_FLAG_MC0];
  assign pos_cnt  = (rev_cnt << ang_n) | ang_cnt;

endmodule

// File: rtl/qpc_checker.sv
module qpc_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         enable,
  input logic         tick,
  input logic         dir_up,
  input logic         index,
  input logic         clr_ovf,
  input logic         clr_mc0,
  input logic [W-1:0] ang_cnt,
  input logic [W-1:0] rev_cnt,
  input logic         ovf_flag,
  input logic         mc0_flag
);

  // R1
  a_r1_disable_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (ang_cnt == '0 && rev_cnt == '0));

  // R11
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick && !index) |=> ($stable(ang_cnt) && $stable(rev_cnt)));

  // R3
  a_r3_ovf_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ovf_flag) |-> $past(enable && tick));

  // R4
  a_r4_down_step: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && !dir_up && !index && ang_cnt != '0)
      |=> ang_cnt == $past(ang_cnt) - W'(1));

  // R9
  a_r9_mc0_needs_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mc0_flag) |-> $past(enable && tick));

  // R10
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !clr_ovf) |=> ovf_flag);

  // R10
  a_r10_mc0_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (mc0_flag && !clr_mc0) |=> mc0_flag);

endmodule

bind qdec_pos_counter qpc_checker #(.W(W)) u_qpc_checker (
  .clk     (clk),
  .rst_n   (rst_n),
  .enable  (enable),
  .tick    (tick),
  .dir_up  (dir_up),
  .index   (index),
  .clr_ovf (clr_ovf),
  .clr_mc0 (clr_mc0),
  .ang_cnt (ang_cnt),
  .rev_cnt (rev_cnt),
  .ovf_flag(ovf_flag),
  .mc0_flag(mc0_flag)
);

// File: tb/test_qdec_pos_counter.sv
module test_qdec_pos_counter;

  localparam int W  = 16;
  localparam int NW = $clog2(W);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          enable = 1'b0;
  logic          tick = 1'b0;
  logic          dir_up = 1'b1;
  logic          index = 1'b0;
  logic          index_en = 1'b0;
  logic [1:0]    mode = 2'd0;
  logic          period_en = 1'b0;
  logic [NW-1:0] ang_bits = NW'(4);
  logic [W-1:0]  period_val = '0;
  logic          clr_ovf = 1'b0;
  logic          clr_mc0 = 1'b0;
  logic [W-1:0]  ang_cnt;
  logic [W-1:0]  rev_cnt;
  logic [W-1:0]  pos_cnt;
  logic          ovf_flag;
  logic          mc0_flag;

  always #4 clk = ~clk;

  qdec_pos_counter #(.W(W)) i_qdec_pos_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .enable    (enable),
    .tick      (tick),
    .dir_up    (dir_up),
    .index     (index),
    .index_en  (index_en),
    .mode      (mode),
    .period_en (period_en),
    .ang_bits  (ang_bits),
    .period_val(period_val),
    .clr_ovf   (clr_ovf),
    .clr_mc0   (clr_mc0),
    .ang_cnt   (ang_cnt),
    .rev_cnt   (rev_cnt),
    .pos_cnt   (pos_cnt),
    .ovf_flag  (ovf_flag),
    .mc0_flag  (mc0_flag)
  );

  int    checks = 0;
  int    errors = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_ang = 0, m_rev = 0, m_pos = 0;
  bit m_first = 0, m_ovf = 0, m_mc0 = 0;

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  function automatic int up_step(int v, int top);
    return (v >= top) ? 0 : v + 1;
  endfunction

  function automatic int dn_step(int v, int top);
    return (v == 0) ? top : v - 1;
  endfunction

  task automatic model();
    int n, amask, rmask, atop, rtop, pv;
    bit strict, idx, wrap, hit;
    n = int'(ang_bits);
    if (n < 1) n = 1;
    if (n > W - 1) n = W - 1;
    amask = (1 << n) - 1;
    rmask = (1 << (W - n)) - 1;
    pv = int'(period_val);
    atop = period_en ? (pv & amask) : amask;
    rtop = period_en ? ((pv >> n) & rmask) : rmask;
    strict = (mode >= 2);
    idx = index_en && index;
    wrap = 0;
    hit = 0;
    if (!rst_n) begin
      m_ang = 0; m_rev = 0; m_first = 0; m_ovf = 0; m_mc0 = 0;
    end else begin
      if (!enable) begin
        m_ang = 0; m_rev = 0; m_first = 0;
      end else if (!strict && idx) begin
        m_ang = dir_up ? 0 : atop;
        m_rev = dir_up ? up_step(m_rev, rtop) : dn_step(m_rev, rtop);
      end else if (strict && idx && !m_first) begin
        m_ang = 0;
        m_first = 1;
      end else if (tick) begin
        if (dir_up) begin
          if (m_ang >= atop) begin m_ang = 0; wrap = 1; end
          else begin m_ang++; hit = (m_ang == atop); end
        end else begin
          if (m_ang == 0) begin m_ang = atop; wrap = 1; end
          else begin m_ang--; hit = (m_ang == 0); end
        end
        if (wrap && (strict || !index_en))
          m_rev = dir_up ? up_step(m_rev, rtop) : dn_step(m_rev, rtop);
      end
      m_ovf = wrap || (m_ovf && !clr_ovf);
      m_mc0 = hit || (m_mc0 && !clr_mc0);
    end
    m_pos = ((m_rev << n) | m_ang) & ((1 << W) - 1);
  endtask

  task automatic compare();
    chk(cur_req, "ang_cnt", int'(ang_cnt), m_ang);
    chk(cur_req, "rev_cnt", int'(rev_cnt), m_rev);
    chk(cur_req, "pos_cnt", int'(pos_cnt), m_pos);
    chk(cur_req, "ovf_flag", int'(ovf_flag), int'(m_ovf));
    chk(cur_req, "mc0_flag", int'(mc0_flag), int'(m_mc0));
  endtask

  task automatic cyc();
    @(posedge clk);
    model();
    @(negedge clk);
    cycles++;
    compare();
  endtask

  task automatic ticks(input int cnt, input bit up);
    dir_up = up;
    tick = 1'b1;
    for (int i = 0; i < cnt; i++) cyc();
    tick = 1'b0;
  endtask

  task automatic pulse_index(input bit with_tick, input bit up);
    dir_up = up;
    index = 1'b1;
    tick = with_tick;
    cyc();
    index = 1'b0;
    tick = 1'b0;
  endtask

  task automatic restart();
    enable = 1'b0;
    cyc();
    enable = 1'b1;
    cyc();
  endtask

  initial begin
    while (!done) begin
      @(posedge clk);
      if (cycles > 200000 && !done) begin
        done = 1;
        errors++;
        checks++;
        $display("FAIL watchdog actual %0d expected below 200000 cycles", cycles);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    // R1: reset state
    cur_req = "R1";
    @(negedge clk);
    for (int i = 0; i < 3; i++) cyc();
    rst_n = 1'b1;
    for (int i = 0; i < 4; i++) cyc();
    chk("R1", "reset ang_cnt", int'(ang_cnt), 0);
    chk("R1", "reset ovf_flag", int'(ovf_flag), 0);

    // R3 R6 R9: relaxed mode, index disabled, default tops, N=4
    mode = 2'd1; index_en = 1'b0; period_en = 1'b0; ang_bits = NW'(4);
    enable = 1'b1;
    cur_req = "R3";
    cyc();
    ticks(15, 1'b1);
    chk("R9", "mc0 at top", int'(mc0_flag), 1);
    ticks(1, 1'b1);
    chk("R3", "up wrap ang", int'(ang_cnt), 0);
    chk("R6", "rev after up wrap", int'(rev_cnt), 1);
    chk("R2", "pos after wrap", int'(pos_cnt), 16);
    chk("R3", "ovf after up wrap", int'(ovf_flag), 1);

    // R6: index ignored with index_en low
    cur_req = "R6";
    ticks(2, 1'b1);
    pulse_index(1'b0, 1'b1);
    chk("R6", "index ignored ang", int'(ang_cnt), 2);

    // R11: idle hold
    cur_req = "R11";
    for (int i = 0; i < 5; i++) cyc();
    chk("R11", "idle ang", int'(ang_cnt), 2);

    // R10: clear
    cur_req = "R10";
    clr_ovf = 1'b1; clr_mc0 = 1'b1;
    cyc();
    clr_ovf = 1'b0; clr_mc0 = 1'b0;
    chk("R10", "ovf cleared", int'(ovf_flag), 0);
    chk("R10", "mc0 cleared", int'(mc0_flag), 0);

    // R4 R9: count down to zero then wrap with a clear in the same cycle
    cur_req = "R4";
    ticks(2, 1'b0);
    chk("R9", "mc0 at zero down", int'(mc0_flag), 1);
    clr_ovf = 1'b1;
    ticks(1, 1'b0);
    clr_ovf = 1'b0;
    chk("R4", "down wrap ang", int'(ang_cnt), 15);
    chk("R10", "set wins over clear", int'(ovf_flag), 1);
    chk("R6", "rev after down wrap", int'(rev_cnt), 0);

    // R2 R4 R8: period tops, angular top 9 revolution top 3
    cur_req = "R2";
    period_en = 1'b1; period_val = 16'h0039;
    restart();
    chk("R1", "disable cleared ang", int'(ang_cnt), 0);
    ticks(1, 1'b0);
    chk("R4", "period down wrap ang", int'(ang_cnt), 9);
    chk("R8", "rev down wrap to top", int'(rev_cnt), 3);
    chk("R2", "pos split", int'(pos_cnt), 16'h39);
    ticks(1, 1'b1);
    chk("R8", "rev up wrap to zero", int'(rev_cnt), 0);
    ticks(25, 1'b1);

    // R5: relaxed mode with index
    cur_req = "R5";
    mode = 2'd0; index_en = 1'b1; period_en = 1'b0;
    restart();
    ticks(5, 1'b1);
    pulse_index(1'b1, 1'b1);
    chk("R5", "index reload up ang", int'(ang_cnt), 0);
    chk("R5", "index rev step", int'(rev_cnt), 1);
    ticks(20, 1'b1);
    chk("R5", "wrap no rev step", int'(rev_cnt), 1);
    chk("R5", "ang after 20", int'(ang_cnt), 4);
    pulse_index(1'b0, 1'b0);
    chk("R5", "index reload down ang", int'(ang_cnt), 15);
    chk("R5", "index rev down", int'(rev_cnt), 0);

    // R7: strict mode first index only
    cur_req = "R7";
    mode = 2'd3;
    restart();
    ticks(3, 1'b1);
    pulse_index(1'b1, 1'b1);
    chk("R7", "first index zero", int'(ang_cnt), 0);
    ticks(2, 1'b1);
    pulse_index(1'b0, 1'b1);
    chk("R7", "second index ignored", int'(ang_cnt), 2);
    ticks(14, 1'b1);
    chk("R7", "strict wrap rev", int'(rev_cnt), 1);
    chk("R7", "strict wrap ang", int'(ang_cnt), 0);
    cur_req = "R1";
    restart();
    ticks(3, 1'b1);
    pulse_index(1'b0, 1'b1);
    chk("R1", "first index re-armed", int'(ang_cnt), 0);

    // R2: width clamp
    cur_req = "R2";
    mode = 2'd1; index_en = 1'b0; ang_bits = '0;
    restart();
    ticks(3, 1'b1);
    chk("R2", "N=0 as 1 ang", int'(ang_cnt), 1);
    chk("R2", "N=0 as 1 rev", int'(rev_cnt), 1);
    chk("R2", "N=0 as 1 pos", int'(pos_cnt), 3);
    ang_bits = NW'(15);
    restart();
    ticks(40, 1'b0);

    // random mix, configuration changed only while disabled
    cur_req = "R3";
    for (int seg = 0; seg < 40; seg++) begin
      enable = 1'b0;
      mode = 2'($urandom_range(3));
      index_en = 1'($urandom_range(1));
      period_en = 1'($urandom_range(1));
      ang_bits = NW'($urandom_range(6));
      period_val = W'($urandom);
      cyc();
      enable = 1'b1;
      for (int i = 0; i < 150; i++) begin
        tick = ($urandom_range(99) < 60);
        if ($urandom_range(99) < 8) dir_up = ~dir_up;
        index = ($urandom_range(99) < 6);
        clr_ovf = ($urandom_range(99) < 5);
        clr_mc0 = ($urandom_range(99) < 5);
        if ($urandom_range(999) < 5) enable = 1'b0; else enable = 1'b1;
        cyc();
      end
      tick = 1'b0; index = 1'b0; clr_ovf = 1'b0; clr_mc0 = 1'b0;
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule